// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps a record of why the host processor was last reset. It samples the processor's reset indication and, each cycle the processor is held in reset, adds every cause the power controller currently permits to a sticky register. The permitting input is a two-bit category from the power controller: nothing pending, a low-power entry, or a software or peripheral request. A debug request that resets everything but the debug logic counts only when the category is "nothing pending". Power-on is recorded by the power-on reset itself.

Right after power-on the recorder stays silent until the processor has come out of reset once. This keeps the cold-boot record free of other causes. Software reads the register through a one-word port and removes bits it has handled by writing ones to them. Generating the resets is not part of this block.

Top module: `rstcause_rec`

## Requirements
- R1: While `por_ni` is low, and right after it rises, `cause_o` reads only bit 0 (power-on) set.
- R2: A write with `wr_en_i` high clears every bit of `cause_o` at the positions where `wr_data_i` is 1, from the next cycle on. Bits written with 0 keep their value.
- R3: After power-on, no cause is recorded until `cpu_rst_ni` has been sampled high at least once. This holds even while requests and categories are active.
- R4: With the category at 1 (low-power entry) and the processor in reset, bit 1 is set.
- R5: Bit 2 (debug module-external reset) is set only when `ndm_req_i` is high and the category is 0 (nothing pending). The same request under category 1, 2 or 3 records nothing.
- R6: With category 2 (software/peripheral), `sw_req_i` high and the processor in reset, bit 3 is set.
- R7: With category 2 and the processor in reset, bit 4+i is set for each high bit i of `hw_req_i`. Several of these bits may be set in one capture.
- R8: While `cpu_rst_ni` is high, no cause bit is set, whatever the requests and category.
- R9: If a clearing write and a capture hit the same bit in the same cycle, the bit ends up set.
- R10: Captures accumulate. Bits already set stay set when a later capture records a different cause.
- R11: Category 3 is reserved and authorizes no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous assert |
| cpu_rst_ni | input | 1 | Processor reset state, low while the processor is in reset (synchronous to clk_i) |
| category_i | input | 2 | Power controller reset category: 0 none, 1 low-power entry, 2 software/peripheral, 3 reserved |
| ndm_req_i | input | 1 | Debug module-external reset request |
| sw_req_i | input | 1 | Software reset request flag |
| hw_req_i | input | NUM_HW | Peripheral reset request sources, one bit each |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | NUM_HW+4 | Write-one-to-clear mask |
| cause_o | output | NUM_HW+4 | Recorded causes: bit 0 power-on, 1 low-power, 2 debug, 3 software, 4+ peripheral |

## Verification
A software clear and a hardware capture can land on the same register bit in the same cycle. The bench forces this directly by writing all ones while a software-request capture is in progress. It also lets random writes overlap random captures over thousands of cycles. In each case the expected result is the old value with the written bits removed and then the captured bits added back. The second overlap is the release of the power-on mute at the same edge as other inputs change; the reference model handles it with its own mute flag.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

  typedef enum logic [1:0] {
    CAT_NONE   = 2'd0,
    CAT_LOWPWR = 2'd1,
    CAT_REQ    = 2'd2,
    CAT_RSVD   = 2'd3
  } rst_cat_e;

  localparam int unsigned BIT_POR  = 0;
  localparam int unsigned BIT_LP   = 1;
  localparam int unsigned BIT_NDM  = 2;
  localparam int unsigned BIT_SW   = 3;
  localparam int unsigned HW_BASE  = 4;

  // Authorization rules, one per cause class.
  function automatic logic lp_allowed(rst_cat_e c);
    return c == CAT_LOWPWR;
  endfunction

  function automatic logic ndm_allowed(rst_cat_e c, logic req);
    return req && (c == CAT_NONE);
  endfunction

  function automatic logic req_allowed(rst_cat_e c, logic req);
    return req && (c == CAT_REQ);
  endfunction

endpackage

// File: rtl/rstcause_mute.sv
module rstcause_mute (
  input  logic clk_i,
  input  logic por_ni,
  input  logic cpu_rst_ni,
  output logic muted_o
);

  // Set by power-on; cleared the first time the processor is seen running.
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)         muted_o <= 1'b1;
    else if (cpu_rst_ni) muted_o <= 1'b0;
  end

endmodule

// File: rtl/rstcause_auth.sv
module rstcause_auth
  import rstcause_pkg::*;
#(
  parameter int unsigned NUM_HW = 4,
  localparam int unsigned W     = HW_BASE + NUM_HW
) (
  input  logic              cpu_rst_ni,
  input  logic              muted_i,
  input  logic [1:0]        category_i,
  input  logic              ndm_req_i,
  input  logic              sw_req_i,
  input  logic [NUM_HW-1:0] hw_req_i,
  output logic [W-1:0]      cap_o
);

  rst_cat_e cat;
  logic     cap_en;

  assign cat    = rst_cat_e'(category_i);
  assign cap_en = !cpu_rst_ni && !muted_i;

  // Power-on is only ever recorded by the reset value.
  assign cap_o[BIT_POR] = 1'b0;
  assign cap_o[BIT_LP]  = cap_en && lp_allowed(cat);
  assign cap_o[BIT_NDM] = cap_en && ndm_allowed(cat, ndm_req_i);
  assign cap_o[BIT_SW]  = cap_en && req_allowed(cat, sw_req_i);

  for (genvar i = 0; i < NUM_HW; i++) begin : g_hw
    assign cap_o[HW_BASE+i] = cap_en && req_allowed(cat, hw_req_i[i]);
  end

endmodule

// File: rtl/rstcause_store.sv
module rstcause_store #(
  parameter int unsigned W       = 8,
  parameter int unsigned POR_BIT = 0
) (
  input  logic         clk_i,
  input  logic         por_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] cap_i,
  output logic [W-1:0] q_o
);

  // Clear first, then set: a same-cycle capture survives the clear.
  function automatic logic bit_next(logic cur, logic clr, logic set);
    return (cur && !clr) || set;
  endfunction

  for (genvar b = 0; b < W; b++) begin : g_bit
    localparam logic RST_VAL = (b == POR_BIT);
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) q_o[b] <= RST_VAL;
      else         q_o[b] <= bit_next(q_o[b], wr_en_i && wr_data_i[b], cap_i[b]);
    end
  end

endmodule

// File: rtl/rstcause_rec.sv
module rstcause_rec
  import rstcause_pkg::*;
#(
  parameter int unsigned NUM_HW = 4,
  localparam int unsigned W     = HW_BASE + NUM_HW
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              cpu_rst_ni,
  input  logic [1:0]        category_i,
  input  logic              ndm_req_i,
  input  logic              sw_req_i,
  input  logic [NUM_HW-1:0] hw_req_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      cause_o
);

  logic         muted;
  logic [W-1:0] cap_vec;

  rstcause_mute u_mute (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .cpu_rst_ni (cpu_rst_ni),
    .muted_o    (muted)
  );

  rstcause_auth #(.NUM_HW(NUM_HW)) u_auth (
    .cpu_rst_ni (cpu_rst_ni),
    .muted_i    (muted),
    .category_i (category_i),
    .ndm_req_i  (ndm_req_i),
    .sw_req_i   (sw_req_i),
    .hw_req_i   (hw_req_i),
    .cap_o      (cap_vec)
  );

  rstcause_store #(.W(W), .POR_BIT(BIT_POR)) u_store (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cap_i     (cap_vec),
    .q_o       (cause_o)
  );

endmodule

// File: rtl/rstcause_rec_chk.sv
module rstcause_rec_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         por_ni,
  input logic         cpu_rst_ni,
  input logic [1:0]   category_i,
  input logic         ndm_req_i,
  input logic         wr_en_i,
  input logic [W-1:0] wr_data_i,
  input logic [W-1:0] cause_o,
  input logic         muted_i,
  input logic [W-1:0] cap_i
);

  // R2
  clear_applied_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    wr_en_i |=> ((cause_o & $past(wr_data_i) & ~$past(cap_i)) == '0));

  // R3
  mute_holds_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (muted_i && !wr_en_i) |=> (cause_o == $past(cause_o)));

  // R5
  ndm_only_none_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    cap_i[2] |-> (ndm_req_i && category_i == 2'd0));

  // R8
  idle_cpu_no_set_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    cpu_rst_ni |=> ((cause_o & ~$past(cause_o)) == '0));

  // R9
  capture_wins_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (cap_i != '0) |=> ((cause_o & $past(cap_i)) == $past(cap_i)));

  // R11
  reserved_silent_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (category_i == 2'd3) |-> (cap_i == '0));

endmodule

bind rstcause_rec rstcause_rec_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .por_ni     (por_ni),
  .cpu_rst_ni (cpu_rst_ni),
  .category_i (category_i),
  .ndm_req_i  (ndm_req_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .cause_o    (cause_o),
  .muted_i    (muted),
  .cap_i      (cap_vec)
);

// File: tb/rstcause_rec_tb_top.sv
`timescale 1ns/1ps
module rstcause_rec_tb_top;

  localparam int NHW = 4;
  localparam int W   = NHW + 4;

  logic           clk = 1'b0;
  logic           por_n = 1'b0;
  logic           cpu_n = 1'b0;
  logic [1:0]     cat = 2'd0;
  logic           ndm = 1'b0;
  logic           sw = 1'b0;
  logic [NHW-1:0] hw = '0;
  logic           we = 1'b0;
  logic [W-1:0]   wd = '0;
  logic [W-1:0]   cause;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  logic [W-1:0] exp_q = 8'h01;
  bit           exp_mute = 1;

  always #2.5 clk = ~clk;

  rstcause_rec #(.NUM_HW(NHW)) dut_i (
    .clk_i(clk), .por_ni(por_n), .cpu_rst_ni(cpu_n), .category_i(cat),
    .ndm_req_i(ndm), .sw_req_i(sw), .hw_req_i(hw),
    .wr_en_i(we), .wr_data_i(wd), .cause_o(cause)
  );

  // Reference for the cause vector a cycle may add.
  function automatic logic [W-1:0] ref_set(bit in_rst, bit mute, logic [1:0] c,
                                           logic n, logic s, logic [NHW-1:0] h);
    logic [W-1:0] v = '0;
    if (in_rst && !mute) begin
      case (c)
        2'd0: v[2] = n;
        2'd1: v[1] = 1'b1;
        2'd2: begin v[3] = s; v[W-1:4] = h; end
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [W-1:0] s = ref_set(!cpu_n, exp_mute, cat, ndm, sw, hw);
    @(posedge clk);
    if (!por_n) begin
      exp_q = 8'h01; exp_mute = 1;
    end else begin
      exp_q = (exp_q & ~(we ? wd : '0)) | s;
      if (cpu_n) exp_mute = 0;
    end
    @(negedge clk);
  endtask

  task automatic drive(bit c_n, logic [1:0] k, bit n, bit s, logic [NHW-1:0] h,
                       bit w, logic [W-1:0] d);
    cpu_n = c_n; cat = k; ndm = n; sw = s; hw = h; we = w; wd = d;
  endtask

  task automatic clear_all();
    drive(1, 0, 0, 0, '0, 1, '1); tick();
    drive(1, 0, 0, 0, '0, 0, '0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 in reset", cause, 8'h01);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", cause, 8'h01);

    // R3: muted while the processor has not yet left reset
    drive(0, 1, 1, 1, 4'hF, 0, '0); tick();
    drive(0, 2, 1, 1, 4'hF, 0, '0); tick();
    drive(0, 0, 1, 1, 4'hF, 0, '0); tick();
    chk("R3 muted", cause, 8'h01);

    // R8: processor running, nothing recorded
    drive(1, 2, 1, 1, 4'hF, 0, '0); tick(); tick();
    drive(1, 1, 1, 1, 4'hF, 0, '0); tick();
    chk("R8 cpu running", cause, 8'h01);

    // R2: write 0 keeps, write 1 clears
    drive(1, 0, 0, 0, '0, 1, 8'h00); tick();
    chk("R2 write zero", cause, 8'h01);
    clear_all();
    chk("R2 write one", cause, 8'h00);

    // R4
    drive(0, 1, 0, 0, '0, 0, '0); tick();
    chk("R4 low power", cause, 8'h02);
    clear_all();

    // R5
    drive(0, 0, 1, 0, '0, 0, '0); tick();
    chk("R5 ndm none", cause, 8'h04);
    clear_all();
    drive(0, 2, 1, 0, '0, 0, '0); tick();
    chk("R5 ndm blocked", cause, 8'h00);

    // R6 and R7
    drive(0, 2, 0, 1, 4'b0101, 0, '0); tick();
    chk("R6 R7 sw and hw", cause, 8'h58);
    clear_all();
    drive(0, 2, 0, 0, 4'b1110, 0, '0); tick();
    chk("R7 multi hw", cause, 8'hE0);
    clear_all();

    // R11
    drive(0, 3, 1, 1, 4'hF, 0, '0); tick();
    chk("R11 reserved", cause, 8'h00);

    // R9: clear and capture on the same edge
    drive(0, 2, 0, 1, '0, 1, '1); tick();
    chk("R9 capture wins", cause, 8'h08);
    clear_all();

    // R10: accumulation
    drive(0, 1, 0, 0, '0, 0, '0); tick();
    drive(0, 0, 1, 0, '0, 0, '0); tick();
    chk("R10 accumulate", cause, 8'h06);

    // R1 and R3 again on a second power-on
    por_n = 1'b0; drive(0, 1, 1, 1, 4'hF, 0, '0);
    @(negedge clk);
    chk("R1 second por", cause, 8'h01);
    tick();
    por_n = 1'b1; exp_q = 8'h01; exp_mute = 1;
    tick(); tick();
    chk("R3 second mute", cause, 8'h01);

    // Random phase, checked every cycle against the reference.
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 2) == 0, 2'($urandom % 4), 1'($urandom), 1'($urandom),
            NHW'($urandom), ($urandom % 5) == 0, W'($urandom));
      tick();
      chk("R2 R9 R10 random", cause, exp_q);
    end

    finish_up();
  end

endmodule